// File: doc/BRIEF.md
# Rectangle Solid Fill Engine

The engine paints an axis-aligned rectangle in byte-addressed video memory with a single colour. A one-cycle `start` pulse presents the drawing state: destination corner, rectangle size, line pitch and surface base, the pixel format code, the raster-operation code, the two direction flags, the brush colour and the two palette colours. The engine picks the fill colour from the raster-operation code. It works out the real top-left corner from the direction flags and checks the rectangle against the coordinate limit and the end of memory. It then streams the pixels out one byte per handshake on a simple valid/ready write port.

Each pixel is the low bytes of the 32-bit fill value, least significant byte first. Rows are always written from the top-left row downward, at increasing addresses within a row. When the fill completes, the engine reports the updated destination Y so the surrounding register file can write it back. Rejected or empty commands finish with `done` and no memory traffic.

Top module: `rect_fill_engine`

## Requirements
- R1: Raster-operation code 0xF0 fills every pixel with the brush colour `brush_colour`.
- R2: Code 0x00 fills with {0xFF, `pal_black`} and code 0xFF fills with {0xFF, `pal_white`}, the 0xFF byte being bits 31:24 of the fill value.
- R3: The pixel-format code sets the bytes per pixel: 2 gives 1, 3 and 4 give 2, 5 gives 3, 6 gives 4; any other code finishes with no writes.
- R4: A pixel writes the low bytes-per-pixel bytes of the fill value, bits 7:0 first, at consecutive increasing addresses.
- R5: The byte `b` of column `c` in row `r` is written to `base + (y0+r)*pitch + (x0+c)*bpp + b`, in order of row, then column, then byte, with `r` counting up from 0.
- R6: The corner is x0 = `dst_x` when `left_to_right` is 1, else `dst_x + 1 - width`, and y0 = `dst_y` when `top_to_bottom` is 1, else `dst_y + 1 - height`, both modulo 2^16.
- R7: On a completed fill `done` is high for one cycle together with `y_update`. `y_next` is y0 + `height` when `top_to_bottom` is 1, else y0. No destination X is reported.
- R8: A zero pitch, x0 or y0 above 0x3FFF, or a last byte beyond the end of memory makes the command finish with `done` alone and no writes.
- R9: A raster-operation code other than 0xF0, 0x00 or 0xFF finishes with `done` alone and no writes.
- R10: A zero width or zero height finishes with `done` alone and no writes.
- R11: While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` hold their values.
- R12: `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command pulse, sampled when idle |
| pix_format | input | 4 | Pixel format code |
| rop_code | input | 8 | Raster-operation code |
| left_to_right | input | 1 | X direction flag |
| top_to_bottom | input | 1 | Y direction flag |
| dst_x | input | 16 | Destination X register |
| dst_y | input | 16 | Destination Y register |
| width | input | 16 | Rectangle width in pixels |
| height | input | 16 | Rectangle height in rows |
| pitch | input | 16 | Bytes per line |
| base | input | ADDR_W | Surface byte offset |
| brush_colour | input | 32 | Brush foreground colour |
| pal_black | input | 24 | RGB of palette entry 0 |
| pal_white | input | 24 | RGB of palette entry 1 |
| busy | output | 1 | Command in progress |
| wr_valid | output | 1 | Write byte valid |
| wr_ready | input | 1 | Memory accepts byte |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write byte |
| done | output | 1 | Command finished |
| y_update | output | 1 | `y_next` is valid, completed fill |
| y_next | output | 16 | New destination Y |

## Verification
The hardest case to reach is a memory stall that falls on the last byte of a 3-byte pixel at the end of a row. At that point the row stepping and the held write have to agree. The bench drives `wr_ready` from a shift-register pattern while filling 24-bit rectangles, so stalls land on every byte position and row end. A sweep over every format code, the four raster codes and all four direction combinations reaches the mirrored corners. Rectangles placed to end exactly at, and one line past, the top of memory reach the bounds decision from both sides.

// File: rtl/rect_fill_pkg.sv
package rect_fill_pkg;

    localparam logic [7:0]  ROP_PATTERN = 8'hF0;
    localparam logic [7:0]  ROP_BLACK   = 8'h00;
    localparam logic [7:0]  ROP_WHITE   = 8'hFF;
    localparam logic [15:0] COORD_MAX   = 16'h3FFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } eng_state_e;

    typedef enum logic [1:0] {
        SRC_BRUSH,
        SRC_BLACK,
        SRC_WHITE,
        SRC_NONE
    } colour_src_e;

    typedef struct packed {
        logic [31:0] colour;
        logic [2:0]  bpp;
        logic [15:0] width;
        logic [15:0] height;
        logic [15:0] pitch;
        logic [15:0] y_next;
    } fill_job_t;

    // Bytes per pixel for a format code, zero for an unknown code.
    function automatic logic [2:0] format_bytes(input logic [3:0] code);
        case (code)
            4'd2:       return 3'd1;
            4'd3, 4'd4: return 3'd2;
            4'd5:       return 3'd3;
            4'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

    function automatic colour_src_e rop_source(input logic [7:0] code);
        case (code)
            ROP_PATTERN: return SRC_BRUSH;
            ROP_BLACK:   return SRC_BLACK;
            ROP_WHITE:   return SRC_WHITE;
            default:     return SRC_NONE;
        endcase
    endfunction

    function automatic logic [31:0] pick_colour(
        input colour_src_e src,
        input logic [31:0] brush,
        input logic [23:0] black,
        input logic [23:0] white
    );
        case (src)
            SRC_BRUSH: return brush;
            SRC_BLACK: return {8'hFF, black};
            SRC_WHITE: return {8'hFF, white};
            default:   return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/rect_fill_setup.sv
module rect_fill_setup
    import rect_fill_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [3:0]        pix_format,
    input  logic [7:0]        rop_code,
    input  logic              left_to_right,
    input  logic              top_to_bottom,
    input  logic [15:0]       dst_x,
    input  logic [15:0]       dst_y,
    input  logic [15:0]       width,
    input  logic [15:0]       height,
    input  logic [15:0]       pitch,
    input  logic [ADDR_W-1:0] base,
    input  logic [31:0]       brush_colour,
    input  logic [23:0]       pal_black,
    input  logic [23:0]       pal_white,
    output fill_job_t         job,
    output logic [ADDR_W-1:0] job_addr,
    output logic              job_ok
);
    localparam int WIDE_W = ADDR_W + 36;
    localparam logic [WIDE_W-1:0] MEM_BYTES = WIDE_W'(1) << ADDR_W;

    colour_src_e       src;
    logic [2:0]        bpp;
    logic [15:0]       x0;
    logic [15:0]       y0;
    logic [WIDE_W-1:0] first_byte;
    logic [WIDE_W-1:0] end_byte;
    logic              shape_ok;
    logic              coord_ok;

    always_comb begin
        src = rop_source(rop_code);
        bpp = format_bytes(pix_format);
        // Mirrored directions name the far corner; step back to the near one.
        x0  = left_to_right ? dst_x : dst_x + 16'd1 - width;
        y0  = top_to_bottom ? dst_y : dst_y + 16'd1 - height;

        first_byte = WIDE_W'(base)
                   + WIDE_W'(y0) * WIDE_W'(pitch)
                   + WIDE_W'(x0) * WIDE_W'(bpp);
        // One past the final byte of the last row.
        end_byte   = WIDE_W'(base)
                   + (WIDE_W'(y0) + WIDE_W'(height) - WIDE_W'(1)) * WIDE_W'(pitch)
                   + (WIDE_W'(x0) + WIDE_W'(width)) * WIDE_W'(bpp);

        shape_ok = (width != 16'd0) && (height != 16'd0) && (pitch != 16'd0);
        coord_ok = (x0 <= COORD_MAX) && (y0 <= COORD_MAX);
        job_ok   = (src != SRC_NONE) && (bpp != 3'd0) && shape_ok && coord_ok
                 && (end_byte <= MEM_BYTES);

        job_addr   = first_byte[ADDR_W-1:0];
        job.colour = pick_colour(src, brush_colour, pal_black, pal_white);
        job.bpp    = bpp;
        job.width  = width;
        job.height = height;
        job.pitch  = pitch;
        job.y_next = top_to_bottom ? y0 + height : y0;
    end

endmodule

// File: rtl/rect_fill_walker.sv
module rect_fill_walker
    import rect_fill_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  fill_job_t         job,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic              wr_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              finished
);
    fill_job_t         cur;
    logic              active;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] row_base;
    logic [1:0]        byte_idx;
    logic [15:0]       col;
    logic [15:0]       row;
    logic              pix_end;
    logic              row_end;
    logic              job_end;
    logic [ADDR_W-1:0] next_row;

    always_comb begin
        pix_end  = ({1'b0, byte_idx} == cur.bpp - 3'd1);
        row_end  = pix_end && (col == cur.width - 16'd1);
        job_end  = row_end && (row == cur.height - 16'd1);
        next_row = row_base + ADDR_W'(cur.pitch);
        wr_valid = active;
        wr_addr  = addr_q;
        wr_data  = 8'(cur.colour >> {byte_idx, 3'b000});
        finished = active && wr_ready && job_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            cur      <= '0;
            addr_q   <= '0;
            row_base <= '0;
            byte_idx <= '0;
            col      <= '0;
            row      <= '0;
        end else if (load) begin
            active   <= 1'b1;
            cur      <= job;
            addr_q   <= job_addr;
            row_base <= job_addr;
            byte_idx <= '0;
            col      <= '0;
            row      <= '0;
        end else if (active && wr_ready) begin
            if (!pix_end) begin
                byte_idx <= byte_idx + 2'd1;
                addr_q   <= addr_q + 1'b1;
            end else if (!row_end) begin
                byte_idx <= '0;
                col      <= col + 16'd1;
                addr_q   <= addr_q + 1'b1;
            end else if (!job_end) begin
                byte_idx <= '0;
                col      <= '0;
                row      <= row + 16'd1;
                row_base <= next_row;
                addr_q   <= next_row;
            end else begin
                active <= 1'b0;
            end
        end
    end

    // R11: a stalled byte stays put
    a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R4: bytes of a row go to consecutive addresses
    a_r4_byte_step: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && !row_end |=> wr_valid && (wr_addr == $past(wr_addr) + 1'b1));

    // R5: a new row starts one pitch below the previous row start
    a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
        wr_valid && wr_ready && row_end && !job_end
        |=> wr_addr == $past(row_base) + ADDR_W'($past(cur.pitch)));

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rect_fill_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        pix_format,
    input  logic [7:0]        rop_code,
    input  logic              left_to_right,
    input  logic              top_to_bottom,
    input  logic [15:0]       dst_x,
    input  logic [15:0]       dst_y,
    input  logic [15:0]       width,
    input  logic [15:0]       height,
    input  logic [15:0]       pitch,
    input  logic [ADDR_W-1:0] base,
    input  logic [31:0]       brush_colour,
    input  logic [23:0]       pal_black,
    input  logic [23:0]       pal_white,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output logic              y_update,
    output logic [15:0]       y_next
);
    eng_state_e        state;
    fill_job_t         job;
    logic [ADDR_W-1:0] job_addr;
    logic              job_ok;
    logic              accept;
    logic              load;
    logic              finished;
    logic              upd_q;
    logic [15:0]       y_q;

    rect_fill_setup #(.ADDR_W(ADDR_W)) u_setup (
        .pix_format    (pix_format),
        .rop_code      (rop_code),
        .left_to_right (left_to_right),
        .top_to_bottom (top_to_bottom),
        .dst_x         (dst_x),
        .dst_y         (dst_y),
        .width         (width),
        .height        (height),
        .pitch         (pitch),
        .base          (base),
        .brush_colour  (brush_colour),
        .pal_black     (pal_black),
        .pal_white     (pal_white),
        .job           (job),
        .job_addr      (job_addr),
        .job_ok        (job_ok)
    );

    rect_fill_walker #(.ADDR_W(ADDR_W)) u_walker (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .job      (job),
        .job_addr (job_addr),
        .wr_ready (wr_ready),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .finished (finished)
    );

    always_comb begin
        accept   = (state == ST_IDLE) && start;
        load     = accept && job_ok;
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        y_update = done && upd_q;
        y_next   = y_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            upd_q <= 1'b0;
            y_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        y_q   <= job.y_next;
                        upd_q <= 1'b0;
                        state <= job_ok ? ST_RUN : ST_FINISH;
                    end
                end
                ST_RUN: begin
                    if (finished) begin
                        upd_q <= 1'b1;
                        state <= ST_FINISH;
                    end
                end
                default: begin
                    upd_q <= 1'b0;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R7: completion is a single-cycle event
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: the Y report only accompanies done
    a_r7_update_with_done: assert property (@(posedge clk) disable iff (rst)
        y_update |-> done);

    // R12: memory traffic only while the command is in progress
    a_r12_write_only_busy: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> busy);

    // R8: a command refused at start never reaches the write port
    a_r8_refused_silent: assert property (@(posedge clk) disable iff (rst)
        !busy && start && !job_ok |=> done && !wr_valid && !y_update);

    // R12: while running, the engine finishes only through the walker
    a_r12_run_to_finish: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !finished |=> busy && !done);

endmodule

// File: tb/test_rect_fill_engine.sv
module test_rect_fill_engine;
    localparam int AW       = 12;
    localparam int MEM      = 1 << AW;
    localparam int MAX_EXP  = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    pix_format = '0;
    logic [7:0]    rop_code = '0;
    logic          left_to_right = 1'b1;
    logic          top_to_bottom = 1'b1;
    logic [15:0]   dst_x = '0, dst_y = '0, width = '0, height = '0, pitch = '0;
    logic [AW-1:0] base = '0;
    logic [31:0]   brush_colour = '0;
    logic [23:0]   pal_black = '0, pal_white = '0;
    logic          busy, wr_valid, wr_ready, done, y_update;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [15:0]   y_next;

    rect_fill_engine #(.ADDR_W(AW)) i_rect_fill_engine (
        .clk(clk), .rst(rst), .start(start), .pix_format(pix_format),
        .rop_code(rop_code), .left_to_right(left_to_right),
        .top_to_bottom(top_to_bottom), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height), .pitch(pitch), .base(base),
        .brush_colour(brush_colour), .pal_black(pal_black),
        .pal_white(pal_white), .busy(busy), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .y_update(y_update), .y_next(y_next)
    );

    // 4 time units per period: 250 MHz with a 1 ns unit
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_n = 0;
    int got_n = 0;
    int bad_n = 0;
    int exp_addr [MAX_EXP];
    int exp_data [MAX_EXP];
    bit exp_upd;
    int exp_y;
    bit stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Write monitor: drives ready, logs bytes accepted at the next edge.
    initial begin
        wr_ready = 1'b1;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr_ready = stall_mode ? lfsr[0] : 1'b1;
            #1;
            if (wr_valid && wr_ready) begin
                if (got_n >= exp_n || int'(wr_addr) != exp_addr[got_n]
                    || int'(wr_data) != exp_data[got_n]) begin
                    bad_n++;
                    $display("FAIL R5 write %0d: actual %0h=%0h expected %0h=%0h", got_n,
                             wr_addr, wr_data,
                             (got_n < exp_n) ? exp_addr[got_n] : -1,
                             (got_n < exp_n) ? exp_data[got_n] : -1);
                end
                got_n++;
            end
        end
    end

    // Independent model of the requirements: fills exp_* and picks a tag.
    function automatic string build_expect();
        int bpp, x0, y0, colour, last;
        bit srcok;
        string tag;
        case (pix_format)
            4'd2: bpp = 1;
            4'd3, 4'd4: bpp = 2;
            4'd5: bpp = 3;
            4'd6: bpp = 4;
            default: bpp = 0;
        endcase
        srcok = 1'b1;
        case (rop_code)
            8'hF0: colour = int'(brush_colour);              // R1
            8'h00: colour = int'({8'hFF, pal_black});        // R2
            8'hFF: colour = int'({8'hFF, pal_white});        // R2
            default: begin colour = 0; srcok = 1'b0; end     // R9
        endcase
        x0 = left_to_right ? int'(dst_x) : ((int'(dst_x) + 1 - int'(width)) & 16'hFFFF);
        y0 = top_to_bottom ? int'(dst_y) : ((int'(dst_y) + 1 - int'(height)) & 16'hFFFF);
        last = int'(base) + (y0 + int'(height) - 1) * int'(pitch) + (x0 + int'(width)) * bpp;
        exp_n = 0;
        exp_upd = 1'b0;
        if (!srcok) tag = "R9";
        else if (bpp == 0) tag = "R3";
        else if (width == 0 || height == 0) tag = "R10";
        else if (pitch == 0 || x0 > 16'h3FFF || y0 > 16'h3FFF || last > MEM) tag = "R8";
        else begin
            tag = "R6";
            exp_upd = 1'b1;
            exp_y = top_to_bottom ? ((y0 + int'(height)) & 16'hFFFF) : y0;
            for (int r = 0; r < int'(height); r++)
                for (int c = 0; c < int'(width); c++)
                    for (int b = 0; b < bpp; b++) begin
                        exp_addr[exp_n] = int'(base) + (y0 + r) * int'(pitch) + (x0 + c) * bpp + b;
                        exp_data[exp_n] = (colour >> (8 * b)) & 8'hFF;
                        exp_n++;
                    end
        end
        return tag;
    endfunction

    task automatic run_op(input bit interfere);
        string tag;
        int bad0, got_at_done;
        bit seen;
        tag = build_expect();
        bad0 = bad_n;
        got_n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int t = 0; t < 4000 && !seen; t++) begin
            if (t > 0) @(negedge clk);
            if (interfere && t == 2) start = 1'b1;   // R12: ignored while busy
            if (interfere && t == 3) start = 1'b0;
            #1;
            if (t == 0) check(busy == 1'b1, "R12", "busy after start", busy, 1);
            if (done) begin
                seen = 1'b1;
                check(y_update == exp_upd, exp_upd ? "R7" : tag, "y_update", y_update, exp_upd);
                if (exp_upd) check(int'(y_next) == exp_y, "R7", "y_next", y_next, exp_y);
            end
        end
        check(seen, tag, "done seen (watchdog)", seen, 1);
        got_at_done = got_n;
        check(got_at_done == exp_n, (exp_n == 0) ? tag : "R4", "write count", got_at_done, exp_n);
        check(bad_n == bad0, "R5", "write content/order", bad_n - bad0, 0);
        @(negedge clk); #1;
        check(busy == 1'b0 && done == 1'b0, "R12", "idle after done", busy, 0);
        if (interfere) begin
            repeat (6) @(negedge clk);
            check(got_n == got_at_done, "R12", "no second command", got_n, got_at_done);
        end
    endtask

    initial begin
        brush_colour = 32'hC3B2A190;
        pal_black = 24'h102030;
        pal_white = 24'hE0D0C0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!busy && !wr_valid && !done && !y_update, "R12", "reset state",
              {busy, wr_valid, done, y_update}, 0);

        // Sweep: every format code, four raster codes, four direction pairs
        for (int f = 0; f < 16; f++)
            for (int rc = 0; rc < 4; rc++)
                for (int d = 0; d < 4; d++) begin
                    pix_format = 4'(f);
                    rop_code = (rc == 0) ? 8'hF0 : (rc == 1) ? 8'h00 : (rc == 2) ? 8'hFF : 8'h5A;
                    left_to_right = d[0];
                    top_to_bottom = d[1];
                    dst_x = 16'd5; dst_y = 16'd3; width = 16'd3; height = 16'd2;
                    pitch = 16'd40; base = AW'(12'h100 + f * 8);
                    run_op(1'b0);
                end

        // Stalls on 24-bit pixels across row ends
        stall_mode = 1'b1;
        for (int k = 0; k < 6; k++) begin
            pix_format = (k < 3) ? 4'd5 : 4'd4;
            rop_code = 8'hF0; left_to_right = 1'b1; top_to_bottom = k[0];
            dst_x = 16'(k); dst_y = 16'd9; width = 16'(2 + k); height = 16'd3;
            pitch = 16'd64; base = 12'h040;
            run_op(1'b0);
        end
        stall_mode = 1'b0;

        // R8 boundaries and refusals
        pix_format = 4'd6; rop_code = 8'h00; left_to_right = 1'b1; top_to_bottom = 1'b1;
        dst_x = 0; dst_y = 0; width = 4; height = 1; pitch = 16; base = 12'hFF0;
        run_op(1'b0);                                  // ends exactly at memory top
        height = 2; run_op(1'b0);                      // one row past: refused
        height = 1; pitch = 0; base = 12'h010; run_op(1'b0);
        pitch = 8; dst_x = 16'h4000; run_op(1'b0);
        dst_x = 16'h3FFF; width = 1; base = 12'h000; pitch = 16'h0; run_op(1'b0);
        pitch = 8; dst_x = 16'd1; width = 3; left_to_right = 1'b0; run_op(1'b0);   // x0 wraps
        left_to_right = 1'b1; dst_x = 0; dst_y = 16'd0; height = 2; top_to_bottom = 1'b0;
        run_op(1'b0);                                  // y0 wraps
        top_to_bottom = 1'b1; pix_format = 4'd2; dst_y = 16'h3FFF; height = 1; pitch = 0;
        run_op(1'b0);

        // R10 empty rectangles
        pix_format = 4'd2; rop_code = 8'hFF; pitch = 16'd8; dst_x = 2; dst_y = 2;
        width = 0; height = 3; run_op(1'b0);
        width = 3; height = 0; run_op(1'b0);

        // R12 start while busy
        width = 4; height = 3; rop_code = 8'hF0; base = 12'h200; run_op(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors + bad_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors + bad_n);
        $finish;
    end

endmodule